// File: doc/BRIEF.md
# Column-Serial Configuration Memory Loader

This block fills a two-dimensional configuration store, `ROWS` rows by `COLS` columns (71 by 160 by default), from a one-bit serial stream. Incoming bits are staged in a row-wide shift register, one bit per accepted clock. When the register holds a full column's worth of bits, a one-hot column selector writes the whole register into the selected column in a single cycle and then steps one column to the left. There is no address decoder: each row's data line reaches every cell in that row, and each column's select line enables every cell in that column.

Once the leftmost column has been written, the block raises a done flag, refuses further input and presents the complete store as a flat parallel vector for the surrounding fabric. With the store full, a readback mode walks the columns again from the right edge. Each column is copied in parallel into the same shift register and shifted out serially, top row first.

Top module: `cfg_col_loader`

## Requirements
- R1: After reset, `load_done` is 0, `bit_ready` is 1, `rb_valid` is 0 and every bit of `cfg_flat` is 0.
- R2: Within a column, the first accepted bit is stored in row `ROWS-1` and the last in row 0. Row r of column c appears at `cfg_flat[c*ROWS + r]`.
- R3: The first `ROWS` accepted bits fill column 0 (the rightmost edge). Each later group of `ROWS` bits fills the next column up, ending at column `COLS-1`.
- R4: A column becomes visible on `cfg_flat` one cycle after the clock edge that accepts its last bit. `bit_ready` is low for exactly that one commit cycle and returns high afterwards, unless the store is full.
- R5: A bit is accepted only on an edge where both `bit_valid` and `bit_ready` are high. Cycles with `bit_valid` low do not change the store or the bit position.
- R6: `load_done` rises together with the write of column `COLS-1` and stays high until reset. While it is high, `bit_ready` is 0, input bits are ignored and `cfg_flat` does not change.
- R7: With `load_done` high, holding `readback` high produces the following sequence. After one load cycle, `rb_valid` is high for `ROWS` cycles per column, and `rb_bit` carries rows `ROWS-1` down to 0. Columns are read from 0 up to `COLS-1`, with a single idle cycle between columns. After the last column, `rb_valid` stays low until `readback` drops.
- R8: `readback` has no effect while `load_done` is low: `rb_valid` stays 0 and loading continues.
- R9: Dropping `readback` aborts the readback without altering the store. Raising it again restarts from column 0, row `ROWS-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Serial input bit is present |
| bit_in | input | 1 | Serial configuration bit |
| readback | input | 1 | Readback mode request (level) |
| bit_ready | output | 1 | Block accepts a bit this cycle |
| load_done | output | 1 | All columns written |
| rb_valid | output | 1 | `rb_bit` carries a readback bit |
| rb_bit | output | 1 | Serial readback bit |
| cfg_flat | output | ROWS*COLS | Whole store, bit `c*ROWS + r` is row r of column c |

## Verification
The assertions check several properties on every cycle:
- the column selector stays one-hot;
- `bit_ready` drops for exactly one cycle after every `ROWS`-th accepted bit;
- `load_done` is sticky;
- the store is frozen once full;
- readback output never appears without a full store or an active mode request.

Three things only the bench scenarios can show, by comparing every cycle against a behavioural model:
- that each bit lands in the right row and column;
- that readback returns the stored values in the stated order;
- that aborting and restarting readback begins again at column 0.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_COMMIT,
        ST_FULL,
        ST_RB_LOAD,
        ST_RB_SHIFT,
        ST_RB_END
    } ldr_state_e;

endpackage

// File: rtl/cfg_column.sv
// One column of configuration cells: all rows written together when selected.
module cfg_column #(
    parameter int ROWS = 71
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ROWS-1:0] wr_data,
    output logic [ROWS-1:0] cells
);
    logic [ROWS-1:0] cells_d;
    logic [ROWS-1:0] cells_q;

    always_comb begin
        cells_d = cells_q;
        if (wr_en) begin
            cells_d = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells_q <= '0;
        end else begin
            cells_q <= cells_d;
        end
    end

    assign cells = cells_q;
endmodule

// File: rtl/cfg_col_readmux.sv
// AND-OR read path: the one-hot select picks a column without decoding.
module cfg_col_readmux #(
    parameter int ROWS = 71,
    parameter int COLS = 160
) (
    input  logic [COLS-1:0]           sel,
    input  logic [COLS-1:0][ROWS-1:0] cols,
    output logic [ROWS-1:0]           rd_data
);
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < COLS; c++) begin
            rd_data = rd_data | (cols[c] & {ROWS{sel[c]}});
        end
    end
endmodule

// File: rtl/cfg_col_loader.sv
module cfg_col_loader #(
    parameter int ROWS = 71,
    parameter int COLS = 160
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_valid,
    input  logic                 bit_in,
    input  logic                 readback,
    output logic                 bit_ready,
    output logic                 load_done,
    output logic                 rb_valid,
    output logic                 rb_bit,
    output logic [ROWS*COLS-1:0] cfg_flat
);
    import cfg_loader_pkg::*;

    localparam int CNT_W = $clog2(ROWS + 1);
    localparam logic [CNT_W-1:0] LAST_ROW = CNT_W'(ROWS - 1);
    localparam logic [COLS-1:0] FIRST_COL = COLS'(1);

    typedef struct packed {
        ldr_state_e      state;
        logic [ROWS-1:0] shift;
        logic [CNT_W-1:0] cnt;
        logic [COLS-1:0] sel;
        logic            done;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    logic [COLS-1:0]           col_sel;
    logic [COLS-1:0]           col_we;
    logic [COLS-1:0][ROWS-1:0] col_data;
    logic [ROWS-1:0]           rd_col;
    logic                      commit_en;

    assign col_sel   = ctl_q.sel;
    assign commit_en = (ctl_q.state == ST_COMMIT);

    // Column storage: one select line per column, row data shared by all.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign col_we[c] = commit_en & col_sel[c];
        cfg_column #(.ROWS(ROWS)) u_col (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (col_we[c]),
            .wr_data (ctl_q.shift),
            .cells   (col_data[c])
        );
    end

    cfg_col_readmux #(.ROWS(ROWS), .COLS(COLS)) u_rdmux (
        .sel     (col_sel),
        .cols    (col_data),
        .rd_data (rd_col)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_FILL: begin
                if (bit_valid) begin
                    ctl_d.shift = {ctl_q.shift[ROWS-2:0], bit_in};
                    if (ctl_q.cnt == LAST_ROW) begin
                        ctl_d.cnt   = '0;
                        ctl_d.state = ST_COMMIT;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
            end
            ST_COMMIT: begin
                if (ctl_q.sel[COLS-1]) begin
                    ctl_d.done  = 1'b1;
                    ctl_d.state = ST_FULL;
                end else begin
                    ctl_d.sel   = {ctl_q.sel[COLS-2:0], 1'b0};
                    ctl_d.state = ST_FILL;
                end
            end
            ST_FULL: begin
                if (readback) begin
                    ctl_d.sel   = FIRST_COL;
                    ctl_d.state = ST_RB_LOAD;
                end
            end
            ST_RB_LOAD: begin
                if (!readback) begin
                    ctl_d.state = ST_FULL;
                end else begin
                    ctl_d.shift = rd_col;
                    ctl_d.cnt   = '0;
                    ctl_d.state = ST_RB_SHIFT;
                end
            end
            ST_RB_SHIFT: begin
                if (!readback) begin
                    ctl_d.state = ST_FULL;
                end else begin
                    ctl_d.shift = {ctl_q.shift[ROWS-2:0], 1'b0};
                    if (ctl_q.cnt == LAST_ROW) begin
                        ctl_d.cnt = '0;
                        if (ctl_q.sel[COLS-1]) begin
                            ctl_d.state = ST_RB_END;
                        end else begin
                            ctl_d.sel   = {ctl_q.sel[COLS-2:0], 1'b0};
                            ctl_d.state = ST_RB_LOAD;
                        end
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
            end
            ST_RB_END: begin
                if (!readback) begin
                    ctl_d.state = ST_FULL;
                end
            end
            default: ctl_d.state = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state <= ST_FILL;
            ctl_q.shift <= '0;
            ctl_q.cnt   <= '0;
            ctl_q.sel   <= FIRST_COL;
            ctl_q.done  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bit_ready = (ctl_q.state == ST_FILL);
    assign load_done = ctl_q.done;
    assign rb_valid  = (ctl_q.state == ST_RB_SHIFT);
    assign rb_bit    = ctl_q.shift[ROWS-1];
    assign cfg_flat  = col_data;
endmodule

// File: rtl/cfg_col_loader_chk.sv
module cfg_col_loader_chk #(
    parameter int ROWS = 71,
    parameter int COLS = 160
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bit_valid,
    input logic                 bit_ready,
    input logic                 readback,
    input logic                 load_done,
    input logic                 rb_valid,
    input logic [ROWS*COLS-1:0] cfg_flat,
    input logic [COLS-1:0]      col_sel
);
    localparam int AW = $clog2(ROWS + 1);

    logic [AW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (bit_valid && bit_ready) begin
            acc_q <= (acc_q == AW'(ROWS - 1)) ? '0 : acc_q + 1'b1;
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(col_sel)); // R3
    AST_STALL_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && bit_ready && acc_q == AW'(ROWS - 1)) |=> !bit_ready); // R4
    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_ready && !load_done) |=> (bit_ready || load_done)); // R4
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done); // R6
    AST_DONE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> !bit_ready); // R6
    AST_STORE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> $stable(cfg_flat)); // R6
    AST_RB_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> load_done); // R8
    AST_RB_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        rb_valid |-> $past(readback)); // R7
endmodule

bind cfg_col_loader cfg_col_loader_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .bit_ready (bit_ready),
    .readback  (readback),
    .load_done (load_done),
    .rb_valid  (rb_valid),
    .cfg_flat  (cfg_flat),
    .col_sel   (col_sel)
);

// File: tb/cfg_col_loader_test.sv
`timescale 1ns/1ps
module cfg_col_loader_test;
    localparam int ROWS = 71;
    localparam int COLS = 160;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic readback = 1'b0;
    logic bit_ready, load_done, rb_valid, rb_bit;
    logic [ROWS*COLS-1:0] cfg_flat;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cfg_col_loader #(.ROWS(ROWS), .COLS(COLS)) uut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .readback(readback), .bit_ready(bit_ready), .load_done(load_done),
        .rb_valid(rb_valid), .rb_bit(rb_bit), .cfg_flat(cfg_flat)
    );

    // ---------------- behavioural reference model ----------------
    bit exp_mem [COLS][ROWS];
    bit stage_m [ROWS];
    int cnt_m, col_m, rb_phase, rb_col, rb_cnt;
    bit done_m, commit_m, dirty_m;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (exp_mem[c, r]) exp_mem[c][r] = 1'b0;
            cnt_m = 0; col_m = 0; done_m = 0; commit_m = 0;
            rb_phase = 0; rb_col = 0; rb_cnt = 0; dirty_m = 1;
        end else if (!done_m) begin
            if (commit_m) begin
                for (int r = 0; r < ROWS; r++) exp_mem[col_m][r] = stage_m[r];
                dirty_m = 1;
                commit_m = 0;
                if (col_m == COLS - 1) done_m = 1;
                else col_m++;
            end else if (bit_valid) begin
                stage_m[ROWS - 1 - cnt_m] = bit_in;
                cnt_m++;
                if (cnt_m == ROWS) begin
                    cnt_m = 0;
                    commit_m = 1;
                end
            end
        end else begin
            case (rb_phase)
                0: if (readback) begin rb_phase = 1; rb_col = 0; end
                1: if (!readback) rb_phase = 0; else begin rb_phase = 2; rb_cnt = 0; end
                2: if (!readback) rb_phase = 0;
                   else begin
                       rb_cnt++;
                       if (rb_cnt == ROWS) begin
                           if (rb_col == COLS - 1) rb_phase = 3;
                           else begin rb_col++; rb_phase = 1; end
                       end
                   end
                default: if (!readback) rb_phase = 0;
            endcase
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int first_mismatch();
        for (int c = 0; c < COLS; c++)
            for (int r = 0; r < ROWS; r++)
                if (cfg_flat[c*ROWS + r] !== exp_mem[c][r]) return c*ROWS + r;
        return -1;
    endfunction

    function automatic bit pat(input int c, input int r);
        return ((c * 13 + r * 5 + c * r) % 7) < 3;
    endfunction

    bit wd_hit = 0;

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !wd_hit) begin
            check(bit_ready === (!done_m && !commit_m), "R4/R5 bit_ready",
                  int'(bit_ready), int'(!done_m && !commit_m));
            check(load_done === done_m, "R6 load_done", int'(load_done), int'(done_m));
            check(rb_valid === (rb_phase == 2), "R7 rb_valid",
                  int'(rb_valid), int'(rb_phase == 2));
            if (rb_phase == 2)
                check(rb_bit === exp_mem[rb_col][ROWS - 1 - rb_cnt], "R7 rb_bit",
                      int'(rb_bit), int'(exp_mem[rb_col][ROWS - 1 - rb_cnt]));
            if (dirty_m) begin
                automatic int mm = first_mismatch();
                check(mm < 0, "R2/R3 cfg_flat first bad index", mm, -1);
                dirty_m = 0;
            end
        end
    end

    task automatic send_bit(input bit b);
        forever begin
            @(negedge clk);
            if (bit_ready) begin
                bit_valid = 1'b1;
                bit_in = b;
                break;
            end
            bit_valid = 1'b0;
            bit_in = ~b;
        end
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_valid = 1'b0;
            bit_in = ~bit_in;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        wd_hit = 1;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int rb_seen;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(load_done === 1'b0, "R1 load_done", int'(load_done), 0);
        check(bit_ready === 1'b1, "R1 bit_ready", int'(bit_ready), 1);
        check(rb_valid === 1'b0, "R1 rb_valid", int'(rb_valid), 0);
        check(cfg_flat === '0, "R1 cfg_flat zero", int'(|cfg_flat), 0);

        for (int c = 0; c < COLS; c++) begin
            for (int k = 0; k < ROWS; k++) begin
                if (c % 3 == 1 && k % 5 == 2) idle(2);        // R5 gaps with noise on bit_in
                if (c == 5 && k == 10) begin                  // R8 readback while loading
                    @(negedge clk);
                    bit_valid = 1'b0;
                    readback = 1'b1;
                    repeat (4) @(negedge clk);
                    check(rb_valid === 1'b0, "R8 rb_valid while loading", int'(rb_valid), 0);
                    check(bit_ready === 1'b1, "R8 loading continues", int'(bit_ready), 1);
                    readback = 1'b0;
                end
                send_bit(pat(c, ROWS - 1 - k));
            end
            if (c == 0) begin
                @(negedge clk);
                bit_valid = 1'b0;
                check(bit_ready === 1'b0, "R4 stall in commit cycle", int'(bit_ready), 0);
                check(cfg_flat[ROWS-1:0] === '0, "R4 column not yet written",
                      int'(|cfg_flat[ROWS-1:0]), 0);
                @(negedge clk);
                check(bit_ready === 1'b1, "R4 ready after commit", int'(bit_ready), 1);
                check(cfg_flat[ROWS-1] === pat(0, ROWS - 1), "R2 first bit in top row",
                      int'(cfg_flat[ROWS-1]), int'(pat(0, ROWS - 1)));
                check(cfg_flat[0] === pat(0, 0), "R2 last bit in row 0",
                      int'(cfg_flat[0]), int'(pat(0, 0)));
                check(cfg_flat[ROWS] === 1'b0, "R3 column 1 untouched", int'(cfg_flat[ROWS]), 0);
            end
        end
        idle(2);
        check(load_done === 1'b1, "R6 done after last column", int'(load_done), 1);

        // R6: extra bits are ignored
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_in = i[0];
        end
        @(negedge clk);
        bit_valid = 1'b0;
        check(first_mismatch() < 0, "R6 store unchanged by late bits", first_mismatch(), -1);
        check(cfg_flat[ROWS*COLS-1] === pat(COLS - 1, ROWS - 1), "R3 last column top row",
              int'(cfg_flat[ROWS*COLS-1]), int'(pat(COLS - 1, ROWS - 1)));

        // R7: full readback
        readback = 1'b1;
        rb_seen = 0;
        for (int i = 0; i < COLS * (ROWS + 1) + 10; i++) begin
            @(negedge clk);
            if (rb_valid) rb_seen++;
        end
        check(rb_seen == ROWS * COLS, "R7 readback bit count", rb_seen, ROWS * COLS);
        check(rb_valid === 1'b0, "R7 idle after last column", int'(rb_valid), 0);

        // R9: abort and restart
        readback = 1'b0;
        repeat (3) @(negedge clk);
        check(first_mismatch() < 0, "R9 store intact after readback", first_mismatch(), -1);
        readback = 1'b1;
        repeat (2) @(negedge clk);
        check(rb_valid === 1'b1, "R9 restart valid", int'(rb_valid), 1);
        check(rb_bit === pat(0, ROWS - 1), "R9 restart at column 0 top row",
              int'(rb_bit), int'(pat(0, ROWS - 1)));
        repeat (30) @(negedge clk);
        readback = 1'b0;
        repeat (2) @(negedge clk);
        check(rb_valid === 1'b0, "R9 abort stops output", int'(rb_valid), 0);
        check(first_mismatch() < 0, "R9 store intact after abort", first_mismatch(), -1);
        finish_run();
    end
endmodule